// File: doc/BRIEF.md
# Secure Block Map Configuration Registers

This block is the programmable side of a memory filter that splits a memory range into equal blocks and tags each block as secure or non-secure. It answers a simple 32-bit register bus that carries byte enables and a secure attribute on every access. The table of tags is kept as an array of 32-bit map words. Bit `i` of map word `w` tags block `w*32+i`. A set bit means the block is non-secure. The whole array leaves the block as a flat vector, and a separate transaction checker reads it there.

Software reaches the map words through one index register and one window register. The window always shows the word the index selects. When stepping is enabled, each full-word window access moves the index to the next word. A lock bit in the control register freezes the control, window and interrupt-enable registers until the next reset. Non-secure masters see only the identification words. Every other offset reads as zero for them and ignores their writes.

Top module: `mpcreg_top`

## Requirements
- R1: After reset, control reads 0x00000100 (stepping on, lock off, error response off), the index reads 0, every map word is 0 and the interrupt-enable register reads 1.
- R2: Control (offset 0x000) keeps only bit 4 (error response select, driven on `err_resp_en`), bit 8 (stepping enable) and bit 31 (lock, driven on `lock_active`). Every other bit reads 0 whatever was written.
- R3: Offset 0x010 reads the map word count, NUM_BLOCKS/32 rounded up. Offset 0x014 reads log2 of the block size minus 5.
- R4: The window (offset 0x01C) reads and writes the map word the index (offset 0x018) selects. Bit `i` of word `w` appears on `map_bits[w*32+i]`.
- R5: With stepping on, a full-word window access (byte enables 4'b1111, read or write) advances the index by one and wraps from the last word to 0. A sub-word window access, or any window access with stepping off, leaves the index unchanged.
- R6: A value written to the index is reduced modulo the map word count.
- R7: While lock is set, writes to control, the window and interrupt enable (offset 0x028, bit 0) change nothing and do not advance the index. Index writes and window reads still work. Only reset clears lock.
- R8: A non-secure access below offset 0xFD0 reads 0, and its writes change no register.
- R9: The twelve identification words at 0xFD0 to 0xFFC read 0xC0+k for word k (k = (offset-0xFD0)/4) for secure and non-secure masters alike. Writes to them are ignored.
- R10: Byte-enabled writes to control, index and window merge the enabled lanes into the current value. A write to interrupt enable zero-fills the disabled lanes, so a write whose lane 0 is disabled clears it.
- R11: Every access gets a response exactly one cycle later, with `rsp_valid` high. Write responses and reads of unmapped offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute of the access |
| req_addr | input | 12 | Byte offset in the register space |
| req_be | input | 4 | Byte lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 32 | Read data of that response |
| map_bits | output | NUM_BLOCKS | Non-secure tag per block |
| err_resp_en | output | 1 | Blocked accesses should get an error response |
| lock_active | output | 1 | Lock bit state |
| irq_en | output | 1 | Interrupt-enable bit |

## Verification
A corrupted index shows within one access, because the next window read returns the wrong word or the next window write lands on the wrong bits of `map_bits`. The bench compares `map_bits`, `err_resp_en`, `lock_active` and `irq_en` with its model on every clock, so any stray write to the map or to control appears on the cycle after it happens. A lock that leaks, or a non-secure write that gets through, therefore shows at the ports one cycle after the offending access.

// File: rtl/mpcreg_pkg.sv
package mpcreg_pkg;

  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_NWORDS = 12'h010;
  localparam logic [11:0] OFF_BCFG   = 12'h014;
  localparam logic [11:0] OFF_IDX    = 12'h018;
  localparam logic [11:0] OFF_WIN    = 12'h01C;
  localparam logic [11:0] OFF_INTEN  = 12'h028;
  localparam logic [11:0] OFF_ID_LO  = 12'hFD0;

  localparam int CTRL_ERR_BIT  = 4;
  localparam int CTRL_STEP_BIT = 8;
  localparam int CTRL_LOCK_BIT = 31;
  localparam logic [31:0] CTRL_KEEP  = 32'h8000_0110;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_NWORDS, SEL_BCFG,
    SEL_IDX, SEL_WIN, SEL_INTEN, SEL_ID
  } reg_sel_e;

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] cur,
                                              input logic [31:0] nw,
                                              input logic [3:0]  be);
    return (cur & ~lane_mask(be)) | (nw & lane_mask(be));
  endfunction

  function automatic logic [31:0] wrap_index(input logic [31:0] v,
                                             input int unsigned nw);
    return v % nw;
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] slot);
    return 32'h0000_00C0 + {28'd0, slot};
  endfunction

endpackage

// File: rtl/mpcreg_decode.sv
module mpcreg_decode
  import mpcreg_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        secure,
  output reg_sel_e    sel,
  output logic [3:0]  id_slot,
  output logic        ns_blocked
);

  logic [11:0] a_word;
  assign a_word     = addr & 12'hFFC;
  assign ns_blocked = !secure && (a_word < OFF_ID_LO);
  assign id_slot    = a_word[5:2] - 4'd4;

  always_comb begin
    sel = SEL_NONE;
    if (!ns_blocked) begin
      if (a_word >= OFF_ID_LO) sel = SEL_ID;
      else begin
        case (a_word)
          OFF_CTRL:   sel = SEL_CTRL;
          OFF_NWORDS: sel = SEL_NWORDS;
          OFF_BCFG:   sel = SEL_BCFG;
          OFF_IDX:    sel = SEL_IDX;
          OFF_WIN:    sel = SEL_WIN;
          OFF_INTEN:  sel = SEL_INTEN;
          default:    sel = SEL_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mpcreg_lut.sv
module mpcreg_lut
  import mpcreg_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter int IDXW   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        idx,
  input  logic [31:0]            wdata,
  input  logic [3:0]             be,
  output logic [31:0]            rd_word,
  output logic [NWORDS*32-1:0]   words_flat
);

  logic [31:0] words [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) words[w] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NWORDS; w++)
        if (idx == IDXW'(w)) words[w] <= merge_lanes(words[w], wdata, be);
    end
  end

  assign rd_word = words[idx];

  for (genvar g = 0; g < NWORDS; g++) begin : g_flat
    assign words_flat[g*32 +: 32] = words[g];
  end

  // R4: the map only moves on a window write strobe
  p_map_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words_flat));

endmodule

// File: rtl/mpcreg_top.sv
module mpcreg_top
  import mpcreg_pkg::*;
#(
  parameter int NUM_BLOCKS = 256,
  parameter int BLK_LOG2   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_secure,
  input  logic [11:0]           req_addr,
  input  logic [3:0]            req_be,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic [NUM_BLOCKS-1:0] map_bits,
  output logic                  err_resp_en,
  output logic                  lock_active,
  output logic                  irq_en
);

  localparam int NWORDS = (NUM_BLOCKS + 31) / 32;
  localparam int IDXW   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  reg_sel_e          sel;
  logic [3:0]        id_slot;
  logic              ns_blocked;
  logic [31:0]       ctrl_q;
  logic [IDXW-1:0]   idx_q;
  logic              inten_q;
  logic [31:0]       win_word;
  logic [NWORDS*32-1:0] words_flat;
  logic [31:0]       rd_mux;
  logic              rsp_valid_q;
  logic [31:0]       rsp_rdata_q;

  mpcreg_decode u_dec (
    .addr(req_addr), .secure(req_secure),
    .sel(sel), .id_slot(id_slot), .ns_blocked(ns_blocked)
  );

  // Named access events
  logic acc_wr, acc_rd, full_word, locked, step_on;
  logic ev_ctrl_wr, ev_idx_wr, ev_win_wr, ev_inten_wr, ev_step;
  assign acc_wr      = req_valid && req_write;
  assign acc_rd      = req_valid && !req_write;
  assign full_word   = (req_be == 4'hF);
  assign locked      = ctrl_q[CTRL_LOCK_BIT];
  assign step_on     = ctrl_q[CTRL_STEP_BIT];
  assign ev_ctrl_wr  = acc_wr && (sel == SEL_CTRL)  && !locked;
  assign ev_win_wr   = acc_wr && (sel == SEL_WIN)   && !locked;
  assign ev_inten_wr = acc_wr && (sel == SEL_INTEN) && !locked;
  assign ev_idx_wr   = acc_wr && (sel == SEL_IDX);
  assign ev_step     = (ev_win_wr || (acc_rd && sel == SEL_WIN)) && full_word && step_on;

  mpcreg_lut #(.NWORDS(NWORDS), .IDXW(IDXW)) u_lut (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_win_wr), .idx(idx_q),
    .wdata(req_wdata), .be(req_be), .rd_word(win_word), .words_flat(words_flat)
  );

  logic [31:0] idx_ext, idx_merged;
  logic [IDXW-1:0] idx_wr_val, idx_inc;
  assign idx_ext    = {{(32-IDXW){1'b0}}, idx_q};
  assign idx_merged = merge_lanes(idx_ext, req_wdata, req_be);
  assign idx_wr_val = IDXW'(wrap_index(idx_merged, NWORDS));
  assign idx_inc    = (idx_q == IDXW'(NWORDS - 1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      idx_q   <= '0;
      inten_q <= 1'b1;
    end else begin
      if (ev_ctrl_wr)  ctrl_q  <= merge_lanes(ctrl_q, req_wdata, req_be) & CTRL_KEEP;
      if (ev_idx_wr)   idx_q   <= idx_wr_val;
      else if (ev_step) idx_q  <= idx_inc;
      if (ev_inten_wr) inten_q <= req_wdata[0] & req_be[0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_NWORDS: rd_mux = 32'(NWORDS);
      SEL_BCFG:   rd_mux = 32'(BLK_LOG2 - 5);
      SEL_IDX:    rd_mux = idx_ext;
      SEL_WIN:    rd_mux = win_word;
      SEL_INTEN:  rd_mux = {31'd0, inten_q};
      SEL_ID:     rd_mux = id_word(id_slot);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_rdata_q <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;
  assign map_bits    = words_flat[NUM_BLOCKS-1:0];
  assign err_resp_en = ctrl_q[CTRL_ERR_BIT];
  assign lock_active = locked;
  assign irq_en      = inten_q;

  // R6: index never leaves the map
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < NWORDS);
  // R7: lock is sticky and freezes control, enable and map
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> lock_active);
  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> ($stable(ctrl_q) && $stable(irq_en) && $stable(map_bits)));
  // R8: non-secure writes below the ID area touch nothing
  p_ns_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ns_blocked) |=>
      ($stable(ctrl_q) && $stable(idx_q) && $stable(irq_en) && $stable(map_bits)));
  p_ns_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && ns_blocked) |=> (rsp_rdata == 32'd0));
  // R11: one response per access, one cycle later
  p_rsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

endmodule

// File: tb/sim_mpcreg_top.sv
`timescale 1ns/1ps
module sim_mpcreg_top;

  localparam int NB = 256;
  localparam int LG = 12;
  localparam int NW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [11:0] req_addr = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, err_resp_en, lock_active, irq_en;
  logic [31:0] rsp_rdata;
  logic [NB-1:0] map_bits;

  mpcreg_top #(.NUM_BLOCKS(NB), .BLK_LOG2(LG)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .map_bits(map_bits), .err_resp_en(err_resp_en), .lock_active(lock_active),
    .irq_en(irq_en)
  );

  always #2 clk = ~clk;

  int checks = 0, errs = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] lut_m [NW];
  logic [31:0] ctrl_m;
  int          idx_m;
  logic        inten_m;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < NW; w++) lut_m[w] = 0;
    ctrl_m = 32'h100; idx_m = 0; inten_m = 1;
  endtask

  function automatic logic [31:0] mask_of(input logic [3:0] be);
    logic [31:0] m = 0;
    for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] addr, input bit sec);
    int a = int'(addr) & 'hFFC;
    if (!sec && a < 'hFD0) return 0;
    if (a >= 'hFD0) return 32'hC0 + (a - 'hFD0) / 4;
    case (a)
      'h000: return ctrl_m;
      'h010: return NW;
      'h014: return LG - 5;
      'h018: return idx_m;
      'h01C: return lut_m[idx_m];
      'h028: return {31'd0, inten_m};
      default: return 0;
    endcase
  endfunction

  task automatic model_apply(input bit wr, input bit sec, input logic [11:0] addr,
                             input logic [3:0] be, input logic [31:0] wd);
    int a = int'(addr) & 'hFFC;
    logic [31:0] m = mask_of(be);
    bit lk = ctrl_m[31];
    bit step = ctrl_m[8] && (be == 4'hF);
    if (!sec && a < 'hFD0) return;
    if (!wr) begin
      if (a == 'h01C && step) idx_m = (idx_m + 1) % NW;
      return;
    end
    case (a)
      'h000: if (!lk) ctrl_m = ((ctrl_m & ~m) | (wd & m)) & 32'h8000_0110;
      'h018: idx_m = int'(((idx_m & ~m) | (wd & m)) % NW);
      'h01C: if (!lk) begin
        lut_m[idx_m] = (lut_m[idx_m] & ~m) | (wd & m);
        if (step) idx_m = (idx_m + 1) % NW;
      end
      'h028: if (!lk) inten_m = wd[0] & be[0];
      default: ;
    endcase
  endtask

  // Called at a negedge; response checked at the following negedge
  task automatic acc(input bit wr, input bit sec, input logic [11:0] addr,
                     input logic [3:0] be, input logic [31:0] wd, input string req);
    logic [31:0] exp;
    req_valid = 1; req_write = wr; req_secure = sec;
    req_addr = addr; req_be = be; req_wdata = wd;
    @(posedge clk);
    exp = wr ? 32'd0 : model_read(addr, sec);
    model_apply(wr, sec, addr, be, wd);
    @(negedge clk);
    req_valid = 0;
    chk(req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(req, $sformatf("rdata @%h", addr), rsp_rdata, exp);
  endtask

  task automatic rd(input bit sec, input logic [11:0] a, input string req);
    acc(0, sec, a, 4'hF, 0, req);
  endtask
  task automatic wr(input bit sec, input logic [11:0] a, input logic [3:0] be,
                    input logic [31:0] d, input string req);
    acc(1, sec, a, be, d, req);
  endtask

  task automatic do_reset();
    rst_n = 0; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Cycle-by-cycle comparison of the state outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NB-1:0] expv;
      for (int w = 0; w < NW; w++)
        for (int b = 0; b < 32; b++) expv[w*32+b] = lut_m[w][b];
      checks++;
      if (map_bits !== expv) begin
        errs++;
        $display("FAIL R4 map_bits: actual=%h expected=%h", map_bits, expv);
      end
      chk("R2", "err_resp_en", {31'd0, err_resp_en}, {31'd0, ctrl_m[4]});
      chk("R7", "lock_active", {31'd0, lock_active}, {31'd0, ctrl_m[31]});
      chk("R10", "irq_en", {31'd0, irq_en}, {31'd0, inten_m});
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(1, 12'h000, "R1"); rd(1, 12'h018, "R1"); rd(1, 12'h028, "R1");
    rd(1, 12'h01C, "R1");                 // advances index: R5
    rd(1, 12'h018, "R5");
    // R3 size registers
    rd(1, 12'h010, "R3"); rd(1, 12'h014, "R3");
    // R2 control masking
    wr(1, 12'h000, 4'hF, 32'h7FFF_FFFF, "R2"); rd(1, 12'h000, "R2");
    // R4/R5 window fill with wrap
    wr(1, 12'h018, 4'hF, 32'd3, "R6");
    for (int k = 0; k < 6; k++) wr(1, 12'h01C, 4'hF, 32'h0000_0021 << k, "R5");
    rd(1, 12'h018, "R5");
    chk("R4", "map bit of block 101", {31'd0, map_bits[3*32+5]}, {31'd0, lut_m[3][5]});
    chk("R4", "map bit of block 101 set", {31'd0, map_bits[101]}, 32'd1);
    wr(1, 12'h018, 4'hF, 32'd3, "R4"); rd(1, 12'h01C, "R4");
    // R6 modulo index
    wr(1, 12'h018, 4'hF, 32'd13, "R6"); rd(1, 12'h018, "R6");
    // R10 sub-word window merge, no advance (R5)
    wr(1, 12'h01C, 4'b0010, 32'hAAAA_BBBB, "R10"); rd(1, 12'h018, "R5");
    rd(1, 12'h01E, "R10");               // sub-word address, full lanes
    wr(1, 12'h01D, 4'b0100, 32'h00CC_0000, "R10"); rd(1, 12'h018, "R5");
    // R10 control halfword merge clears stepping
    wr(1, 12'h000, 4'b0011, 32'h0, "R10"); rd(1, 12'h000, "R10");
    wr(1, 12'h01C, 4'hF, 32'h1234_5678, "R5"); rd(1, 12'h018, "R5");
    rd(1, 12'h01C, "R5"); rd(1, 12'h018, "R5");
    // R10 interrupt enable zero-fill
    wr(1, 12'h028, 4'b0010, 32'hFFFF_FFFF, "R10"); rd(1, 12'h028, "R10");
    wr(1, 12'h028, 4'hF, 32'd1, "R10"); rd(1, 12'h028, "R10");
    // R8 non-secure isolation
    rd(0, 12'h000, "R8"); rd(0, 12'h01C, "R8"); rd(0, 12'h010, "R8");
    wr(0, 12'h018, 4'hF, 32'd1, "R8"); wr(0, 12'h01C, 4'hF, 32'hFFFF_FFFF, "R8");
    wr(0, 12'h000, 4'hF, 32'hFFFF_FFFF, "R8");
    rd(1, 12'h018, "R8"); rd(1, 12'h000, "R8");
    // R9 identification words
    rd(0, 12'hFD0, "R9"); rd(1, 12'hFE4, "R9"); rd(0, 12'hFFC, "R9");
    wr(1, 12'hFD0, 4'hF, 32'hDEAD_BEEF, "R9"); rd(1, 12'hFD0, "R9");
    // R11 unmapped and write-only offsets
    rd(1, 12'h024, "R11"); rd(1, 12'h100, "R11");
    wr(1, 12'h034, 4'hF, 32'hFFFF_FFFF, "R11"); rd(1, 12'h018, "R11");
    @(negedge clk);
    chk("R11", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    // R7 lockdown
    wr(1, 12'h000, 4'hF, 32'h8000_0100, "R7"); rd(1, 12'h000, "R7");
    wr(1, 12'h000, 4'hF, 32'h0, "R7"); rd(1, 12'h000, "R7");
    wr(1, 12'h01C, 4'hF, 32'hFFFF_0000, "R7"); rd(1, 12'h018, "R7");
    rd(1, 12'h01C, "R7"); rd(1, 12'h018, "R7");
    wr(1, 12'h018, 4'hF, 32'd2, "R7"); rd(1, 12'h018, "R7");
    wr(1, 12'h028, 4'hF, 32'd0, "R7"); rd(1, 12'h028, "R7");
    // Only reset clears lock (R1, R7)
    do_reset();
    rd(1, 12'h000, "R7"); rd(1, 12'h01C, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule